// File: doc/BRIEF.md
# Speculative and Committed Register File Pair

This block keeps two register files of identical shape for an out-of-order core with in-order retirement. The speculative file takes execution results as soon as they come back, in whatever order they finish. Both operand read ports are served from it. The committed file is written only by the retirement stage, one instruction at a time in program order. It therefore always holds the architecturally correct state.

The committed copy is never read by the pipeline during normal operation. When an exception or a mispredicted branch forces the machine back to its last correct state, a single rollback strobe replaces every speculative register with its committed value in one clock edge. Any results written out of order after that point are discarded.

Register 0 is hard-wired to zero in both files. Reads are combinational. A result written back in the same cycle as a read of the same register is forwarded straight to that read port.

Top module: `spec_commit_regfile`

## Requirements
- R1: A synchronous active-low reset clears every register of both files to zero, so every read after reset returns 0, and so does every read after a rollback that immediately follows reset.
- R2: A writeback (wb_valid high, wb_idx nonzero) stores wb_value into the speculative register wb_idx at the clock edge; writebacks may target registers in any order.
- R3: The two read ports are independent; each returns, combinationally, the speculative value of the register its own index selects.
- R4: When wb_valid is high, rollback is low and wb_idx equals a port's nonzero read index, that port returns wb_value in the same cycle.
- R5: Register 0 reads as zero on both ports at all times; writebacks and commits addressed to index 0 have no effect.
- R6: A commit write (cm_valid high) changes no read port value, either in its own cycle or later, until a rollback occurs.
- R7: A rollback pulse replaces every speculative register with its committed value at a single clock edge.
- R8: A writeback in the same cycle as a rollback is dropped: it is neither stored nor forwarded to the read ports.
- R9: A commit in the same cycle as a rollback is applied to the committed file first, and the rollback copies the updated value.
- R10: A commit to a nonzero index changes only that committed register; all others keep their values, as shown by reads after a later rollback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_value | output | 32 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_value | output | 32 | Read port B data |
| wb_valid | input | 1 | Writeback strobe into the speculative file |
| wb_idx | input | 5 | Writeback register index |
| wb_value | input | 32 | Writeback data |
| cm_valid | input | 1 | Commit strobe into the committed file |
| cm_idx | input | 5 | Commit register index |
| cm_value | input | 32 | Commit data |
| rollback | input | 1 | Restore the speculative file from the committed file |

## Verification
The assertions assume that every index input is below the register count and that all strobes are known (0 or 1) whenever reset is released. With the default count of 32 and 5-bit indices, every index value is legal, so the range assumption holds automatically. The stimulus drives only 0 or 1 on the strobes and keeps them at 0 while reset is held.

The directed phases aim writebacks, commits and rollbacks at the same cycles so that each same-cycle priority rule is exercised. A random phase then mixes all three strobes freely, including index 0, and checks both read ports against the behavioural model after every cycle.

// File: rtl/srf_pkg.sv
// Package srf_pkg
// Shared defaults for the speculative/committed register file pair.
// Assumes: register count is a power of two, at least 2.
package srf_pkg;
    parameter int SRF_NUM_REGS = 32;
    parameter int SRF_DATA_W   = 32;
endpackage

// File: rtl/srf_commit_file.sv
// Module srf_commit_file
// Holds committed (architectural) state. It is written only by in-order
// commit writes and is read only as the source of a rollback. It also
// exports the value each register will take after this cycle's commit,
// so that a rollback in the same cycle copies the updated value.
// Assumes: cm_idx_i is below NUM_REGS whenever cm_valid_i is high.
module srf_commit_file #(
    parameter int NUM_REGS = srf_pkg::SRF_NUM_REGS,
    parameter int DATA_W   = srf_pkg::SRF_DATA_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cm_valid_i,
    input  logic [IDX_W-1:0]                 cm_idx_i,
    input  logic [DATA_W-1:0]                cm_value_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  arch_next_o
);
    logic [NUM_REGS-1:0][DATA_W-1:0] arch_q;

    // Entry 0 is constant zero; every other entry has its own write enable.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign arch_q[g]      = '0;
            assign arch_next_o[g] = '0;
        end else begin : g_reg
            logic hit;
            // Decode whether this cycle's commit targets this entry.
            always_comb hit = cm_valid_i && (cm_idx_i == IDX_W'(g));
            // Value after this cycle's commit, used by rollback.
            always_comb arch_next_o[g] = hit ? cm_value_i : arch_q[g];
            // Committed register storage with synchronous clear.
            always_ff @(posedge clk) begin
                if (!rst_n) arch_q[g] <= '0;
                else        arch_q[g] <= arch_next_o[g];
            end
        end
    end

    // R6, R10: with no commit, the committed state does not move.
    assert_commit_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cm_valid_i |=> $stable(arch_q));

    // R10: a commit to a nonzero index lands in that entry.
    assert_commit_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid_i && cm_idx_i != '0) |=> arch_q[$past(cm_idx_i)] == $past(cm_value_i));
endmodule

// File: rtl/srf_spec_file.sv
// Module srf_spec_file
// Holds speculative state. Out-of-order writebacks land here. A rollback
// overwrites every entry at once from the restore vector, and it takes
// priority over a writeback in the same cycle.
// Assumes: wb_idx_i is below NUM_REGS whenever wb_valid_i is high.
module srf_spec_file #(
    parameter int NUM_REGS = srf_pkg::SRF_NUM_REGS,
    parameter int DATA_W   = srf_pkg::SRF_DATA_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wb_valid_i,
    input  logic [IDX_W-1:0]                 wb_idx_i,
    input  logic [DATA_W-1:0]                wb_value_i,
    input  logic                             rollback_i,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  restore_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  spec_o
);
    logic [NUM_REGS-1:0][DATA_W-1:0] spec_q;

    // Entry 0 is constant zero; the others pick rollback, writeback or hold.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign spec_q[g] = '0;
        end else begin : g_reg
            logic wr_hit;
            // Decode whether this cycle's writeback targets this entry.
            always_comb wr_hit = wb_valid_i && (wb_idx_i == IDX_W'(g));
            // Speculative register: rollback first, then writeback.
            always_ff @(posedge clk) begin
                if (!rst_n)          spec_q[g] <= '0;
                else if (rollback_i) spec_q[g] <= restore_i[g];
                else if (wr_hit)     spec_q[g] <= wb_value_i;
            end
        end
    end

    assign spec_o = spec_q;

    // R7, R8, R9: after a rollback the whole file equals the restore image.
    assert_rollback_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_i |=> spec_q == $past(restore_i));

    // R2: a writeback without rollback lands in its entry.
    assert_writeback_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_i && !rollback_i && wb_idx_i != '0)
            |=> spec_q[$past(wb_idx_i)] == $past(wb_value_i));
endmodule

// File: rtl/srf_read_port.sv
// Module srf_read_port
// One combinational read port on the speculative file. It forwards a
// same-cycle writeback unless a rollback is also asserted, and it returns
// zero for index 0.
// Assumes: rd_idx_i is below NUM_REGS.
module srf_read_port #(
    parameter int NUM_REGS = srf_pkg::SRF_NUM_REGS,
    parameter int DATA_W   = srf_pkg::SRF_DATA_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  spec_i,
    input  logic [IDX_W-1:0]                 rd_idx_i,
    input  logic                             wb_valid_i,
    input  logic [IDX_W-1:0]                 wb_idx_i,
    input  logic [DATA_W-1:0]                wb_value_i,
    input  logic                             rollback_i,
    output logic [DATA_W-1:0]                rd_value_o
);
    logic fwd;

    // Decide whether this cycle's writeback bypasses the stored value.
    always_comb fwd = wb_valid_i && !rollback_i && (wb_idx_i == rd_idx_i);

    // Select zero, forwarded data or stored data.
    always_comb begin
        if (rd_idx_i == '0) rd_value_o = '0;
        else if (fwd)       rd_value_o = wb_value_i;
        else                rd_value_o = spec_i[rd_idx_i];
    end

    // R5: index 0 always reads zero.
    assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx_i == '0 |-> rd_value_o == '0);
endmodule

// File: rtl/spec_commit_regfile.sv
// Module spec_commit_regfile
// Top level of the speculative/committed register file pair: two read
// ports and one writeback port on the speculative file, one commit port
// on the committed file, and a rollback strobe that restores the
// speculative file from committed state in one cycle.
// Assumes: synchronous active-low reset; all indices are in range.
module spec_commit_regfile #(
    parameter int NUM_REGS = srf_pkg::SRF_NUM_REGS,
    parameter int DATA_W   = srf_pkg::SRF_DATA_W,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int NUM_RD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_value,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_value,
    input  logic              wb_valid,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              cm_valid,
    input  logic [IDX_W-1:0]  cm_idx,
    input  logic [DATA_W-1:0] cm_value,
    input  logic              rollback
);
    logic [NUM_REGS-1:0][DATA_W-1:0] arch_next;
    logic [NUM_REGS-1:0][DATA_W-1:0] spec_vals;
    logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_val;

    // Gather the read port indices and spread out the results.
    always_comb begin
        rd_idx[0]  = rd_a_idx;
        rd_idx[1]  = rd_b_idx;
        rd_a_value = rd_val[0];
        rd_b_value = rd_val[1];
    end

    srf_commit_file #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) commit_file_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cm_valid_i  (cm_valid),
        .cm_idx_i    (cm_idx),
        .cm_value_i  (cm_value),
        .arch_next_o (arch_next)
    );

    srf_spec_file #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) spec_file_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wb_valid_i (wb_valid),
        .wb_idx_i   (wb_idx),
        .wb_value_i (wb_value),
        .rollback_i (rollback),
        .restore_i  (arch_next),
        .spec_o     (spec_vals)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        srf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) port_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .spec_i     (spec_vals),
            .rd_idx_i   (rd_idx[p]),
            .wb_valid_i (wb_valid),
            .wb_idx_i   (wb_idx),
            .wb_value_i (wb_value),
            .rollback_i (rollback),
            .rd_value_o (rd_val[p])
        );
    end

    // R4: a live writeback to the index port A reads is forwarded to it.
    assert_forward_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !rollback && wb_idx == rd_a_idx && rd_a_idx != '0)
            |-> rd_a_value == wb_value);

    // R8: a writeback that coincides with a rollback leaves no trace in storage.
    assert_rollback_beats_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback && wb_valid && wb_idx != '0)
            |=> spec_vals[$past(wb_idx)] == $past(arch_next[wb_idx]));
endmodule

// File: tb/spec_commit_regfile_tb.sv
// Bench for spec_commit_regfile. A behavioural reference model (two integer
// arrays) is updated at every rising edge, and both read ports are compared
// against it in every cycle.
module spec_commit_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wb_idx = '0, cm_idx = '0;
    logic [31:0] rd_a_value, rd_b_value, wb_value = '0, cm_value = '0;
    logic        wb_valid = 1'b0, cm_valid = 1'b0, rollback = 1'b0;

    int unsigned m_spec [32];
    int unsigned m_arch [32];
    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spec_commit_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_value(rd_a_value),
        .rd_b_idx(rd_b_idx), .rd_b_value(rd_b_value),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_value(wb_value),
        .cm_valid(cm_valid), .cm_idx(cm_idx), .cm_value(cm_value),
        .rollback(rollback)
    );

    // Expected value of one read port from the model and the current inputs.
    function automatic int unsigned expect_rd(input logic [4:0] idx);
        if (idx == 0) return 0;
        if (wb_valid && !rollback && wb_idx == idx) return wb_value;
        return m_spec[idx];
    endfunction

    // One cycle: compare the reads mid-cycle, then advance the model at the edge.
    task automatic cyc(input string tag);
        int unsigned ea, eb;
        #2;
        ea = expect_rd(rd_a_idx);
        eb = expect_rd(rd_b_idx);
        vectors++;
        if (rd_a_value !== ea || rd_b_value !== eb) begin
            errors++;
            $display("FAIL %s: idx %0d/%0d actual %h/%h expected %h/%h",
                     tag, rd_a_idx, rd_b_idx, rd_a_value, rd_b_value, ea, eb);
        end
        @(posedge clk);
        if (!rst_n) begin
            foreach (m_spec[i]) begin m_spec[i] = 0; m_arch[i] = 0; end
        end else begin
            if (cm_valid && cm_idx != 0) m_arch[cm_idx] = cm_value;
            if (rollback) m_spec = m_arch;
            else if (wb_valid && wb_idx != 0) m_spec[wb_idx] = wb_value;
        end
        @(negedge clk);
        wb_valid = 0; cm_valid = 0; rollback = 0;
    endtask

    // Read all registers through both ports.
    task automatic sweep(input string tag);
        for (int r = 0; r < 32; r += 2) begin
            rd_a_idx = 5'(r); rd_b_idx = 5'(r + 1);
            cyc(tag);
        end
    endtask

    task automatic wb(input int r, input int unsigned v);
        wb_valid = 1; wb_idx = 5'(r); wb_value = v;
    endtask

    task automatic cm(input int r, input int unsigned v);
        cm_valid = 1; cm_idx = 5'(r); cm_value = v;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        foreach (m_spec[i]) begin m_spec[i] = 32'hdead_beef; m_arch[i] = 32'hdead_beef; end
        @(negedge clk);
        repeat (3) cyc("R1 reset");
        rst_n = 1;
        sweep("R1 spec after reset");
        rollback = 1; cyc("R1 rollback");
        sweep("R1 committed after reset");

        // R2: out-of-order writebacks; R3: independent ports.
        wb(9, 32'h0000_0909); cyc("R2");
        wb(3, 32'h0000_0303); cyc("R2");
        wb(17, 32'h1717_1717); cyc("R2");
        rd_a_idx = 3; rd_b_idx = 17; cyc("R3");
        rd_a_idx = 17; rd_b_idx = 9; cyc("R3");

        // R4: same-cycle forwarding on each port.
        rd_a_idx = 5; rd_b_idx = 9; wb(5, 32'h5555_aaaa); cyc("R4 port a");
        rd_a_idx = 3; rd_b_idx = 9; wb(9, 32'h9999_0000); cyc("R4 port b");

        // R5: index 0 ignores writebacks and commits.
        rd_a_idx = 0; rd_b_idx = 0; wb(0, 32'hffff_ffff); cyc("R5 fwd");
        cm(0, 32'hffff_ffff); cyc("R5 commit");
        rollback = 1; cyc("R5 rollback");
        sweep("R5 after rollback");

        // R6: commits are invisible until rollback.
        wb(4, 32'h0404_0404); cyc("R6");
        rd_a_idx = 4; rd_b_idx = 6; cm(4, 32'h4444_0000); cyc("R6 same cycle");
        cm(6, 32'h6666_0000); cyc("R6 next");
        cm(12, 32'h1212_1212); cyc("R6 later");
        sweep("R6 sweep");

        // R7, R10: rollback restores every register; only committed ones changed.
        wb(20, 32'h2020_2020); cyc("R7 prep");
        rollback = 1; cyc("R7 rollback");
        sweep("R10 sweep");

        // R8: writeback during rollback is dropped and not forwarded.
        rd_a_idx = 21; rd_b_idx = 4; rollback = 1; wb(21, 32'h2121_2121); cyc("R8 no fwd");
        rd_a_idx = 21; cyc("R8 not stored");

        // R9: commit during rollback is copied.
        rd_a_idx = 22; rd_b_idx = 6;
        rollback = 1; cm(22, 32'h2222_5555); cyc("R9 rollback");
        cyc("R9 copied");

        // Random mix of all strobes.
        for (int n = 0; n < 3000; n++) begin
            rd_a_idx = 5'($urandom); rd_b_idx = 5'($urandom);
            if ($urandom_range(0, 9) < 7) wb($urandom_range(0, 31), $urandom);
            if ($urandom_range(0, 9) < 4) cm($urandom_range(0, 31), $urandom);
            if ($urandom_range(0, 19) == 0) rollback = 1;
            cyc("R7 random");
        end
        sweep("R7 final");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule